// File: doc/BRIEF.md
# Packet-Command PIO Burst Sequencer

This block is the device-side controller for a packet command executed in programmed I/O mode on a parallel storage-style task-file interface. The host writes the packet opcode to the command register. The device stays busy for a short settling time and then requests a twelve-byte command descriptor, which the host delivers as six 16-bit writes to the data port. If the descriptor is a READ(10), the block reports the starting address and the block count on a side port so that the media logic can start streaming. It then returns the requested data through the data port in bursts.

The size of each burst is capped by a byte-count limit. The host loads this limit into the two byte-count registers before it issues the command, and the block always rounds the limit down to an even number. Each burst is announced with an interrupt and with the data-request flag set. The actual size of the burst is written back into the byte-count registers. A status read clears a pending interrupt. A final interrupt, with the status showing ready only, marks the end of the command. Illegal commands, unsupported descriptors and a request for the DMA data path all end in an abort.

The block does not store any media. Each word the host reads is taken directly from a ready/valid word stream.

Top module: `atapi_pio_seq`

## Requirements
- R1: After reset the status register (address 7) reads 0x40, the interrupt output is low, no stream word is consumed and the start pulse is low.
- R2: A write of 0xA0 to address 7 while idle sets the status to 0xC0 (busy plus ready) for HOLD_CYC cycles. The status then becomes 0x48 (data request plus ready) with no interrupt. Status bits are: bit 7 busy, bit 6 ready, bit 5 fault, bit 3 data request, bit 0 error. Busy and data request are never set together.
- R3: Six data-port (address 0) writes form the descriptor. Each word carries the even-numbered byte in bits 7:0. Byte 0 is the opcode 0x28. Bytes 2 to 5 hold a big-endian 32-bit address and bytes 7 to 8 hold a big-endian block count. A valid descriptor with a nonzero count raises `rd_start` for exactly one cycle, with the decoded address and count.
- R4: The limit is {address 5, address 4}, sampled when the command is accepted, with bit 0 cleared. A limit that becomes zero after this rounding is treated as 0xFFFE.
- R5: Each burst moves min(remaining bytes, limit) bytes. Total bytes equal count × BLK_BYTES. Before each burst the interrupt rises, status is 0x48, and addresses 4 (low byte) and 5 (high byte) hold the burst size. Each data-port read returns the next stream word in order and consumes exactly one word.
- R6: A status read clears a pending interrupt. The next burst is not announced until every word of the current burst has been read.
- R7: After the last word of the last burst, one more interrupt is raised and the status reads 0x40.
- R8: A READ(10) with a block count of zero moves no data, gives no start pulse, and completes at once with an interrupt and status 0x40.
- R9: Any of the following aborts the command with status 0x41, error register (address 1 read) 0x04, and an interrupt: a command other than 0xA0, 0xA0 with feature bit 0 set (DMA data path), or a descriptor opcode other than 0x28. The next accepted command clears the error.
- R10: Command-register writes while the block is not idle are ignored.
- R11: Between bursts, while the stream is not valid, the status stays 0xC0 and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_wr | input | 1 | Host register write strobe |
| hst_rd | input | 1 | Host register read strobe (reads of address 0 and 7 have side effects) |
| hst_addr | input | 3 | Task-file register address |
| hst_wdata | input | 16 | Host write data (bits 7:0 for byte registers) |
| hst_rdata | output | 16 | Host read data |
| irq | output | 1 | Interrupt request, level |
| blk_data | input | 16 | Stream word from media |
| blk_valid | input | 1 | Stream word available |
| blk_ready | output | 1 | Stream word consumed this cycle |
| rd_start | output | 1 | One-cycle pulse when a read descriptor is accepted |
| rd_lba | output | 32 | Decoded starting block address |
| rd_blocks | output | 16 | Decoded block count |

## Verification
The bench sweeps a reduced configuration across several limits: odd, even, tiny, zero, and larger than the whole transfer. For each limit it runs one, two and three blocks. This exposes a design that fails to round an odd limit, that mishandles the zero limit, or that sizes the final short burst wrongly. Any of these would show up as a wrong byte count in the count registers or as a lost or duplicated stream word. Directed cases check four more behaviours: an interrupt raised before a burst is drained, a command write accepted in the middle of a transfer, a stalled stream that is announced anyway, and a zero-count descriptor. The abort cases check that each illegal command ends with the error status and the abort code, and that the following command clears them.

// File: rtl/atapi_seq_pkg.sv
// Package: shared constants and the sequencer state type.
// Assumes the conventional task-file register numbering and status bit layout,
// which host software decodes directly.
package atapi_seq_pkg;

    // register addresses
    localparam logic [2:0] A_DATA = 3'd0;
    localparam logic [2:0] A_FEAT = 3'd1;   // write: feature, read: error
    localparam logic [2:0] A_NSEC = 3'd2;
    localparam logic [2:0] A_LBAL = 3'd3;
    localparam logic [2:0] A_CNTL = 3'd4;   // byte-count low
    localparam logic [2:0] A_CNTH = 3'd5;   // byte-count high
    localparam logic [2:0] A_DEV  = 3'd6;
    localparam logic [2:0] A_CMD  = 3'd7;   // write: command, read: status

    // status bits
    localparam logic [7:0] S_BUSY  = 8'h80;
    localparam logic [7:0] S_READY = 8'h40;
    localparam logic [7:0] S_FAULT = 8'h20;
    localparam logic [7:0] S_DREQ  = 8'h08;
    localparam logic [7:0] S_ERR   = 8'h01;

    localparam logic [7:0] E_ABORT   = 8'h04;
    localparam logic [7:0] OP_PACKET = 8'hA0;
    localparam logic [7:0] OP_RD10   = 8'h28;

    typedef enum logic [2:0] {
        SQ_IDLE,    // ready for a command
        SQ_HOLD,    // busy after the command, before the packet request
        SQ_PKT,     // collecting the descriptor
        SQ_PREP,    // busy, sizing the next burst
        SQ_XFER     // host draining a burst
    } seq_state_t;

endpackage

// File: rtl/atapi_taskfile.sv
// Task-file byte registers written by the host.
// The byte-count pair is also loaded by the sequencer with each burst size;
// that load takes priority over a host write in the same cycle.
// Only feature bit 0 (DMA data path) is kept, since nothing else uses it.
module atapi_taskfile
    import atapi_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  addr,
    input  logic [7:0]  wdata,
    input  logic        cnt_load,
    input  logic [15:0] cnt_val,
    output logic        dma_sel,
    output logic [7:0]  nsec,
    output logic [7:0]  lba_lo,
    output logic [7:0]  cnt_lo,
    output logic [7:0]  cnt_hi,
    output logic [7:0]  dev
);

    // Purpose: capture host byte writes and burst-size reports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_sel <= 1'b0;
            nsec    <= 8'h00;
            lba_lo  <= 8'h00;
            cnt_lo  <= 8'h00;
            cnt_hi  <= 8'h00;
            dev     <= 8'h00;
        end else begin
            if (wr_en) begin
                case (addr)
                    A_FEAT:  dma_sel <= wdata[0];
                    A_NSEC:  nsec    <= wdata;
                    A_LBAL:  lba_lo  <= wdata;
                    A_CNTL:  cnt_lo  <= wdata;
                    A_CNTH:  cnt_hi  <= wdata;
                    A_DEV:   dev     <= wdata;
                    default: ;
                endcase
            end
            if (cnt_load) begin
                cnt_lo <= cnt_val[7:0];
                cnt_hi <= cnt_val[15:8];
            end
        end
    end

endmodule

// File: rtl/atapi_pkt_collect.sv
// Collects the command descriptor from PKT_WORDS data-port writes and extracts
// the read fields. Each word carries the even-numbered byte in bits 7:0.
// Only the bytes that are decoded are stored. `done` is combinational and
// asserted with the final word; the stored fields are complete by then, because
// the last word carries no decoded byte.
module atapi_pkt_collect #(
    parameter int PKT_WORDS = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        wr_word,
    input  logic [15:0] wdata,
    output logic        done,
    output logic [7:0]  opcode,
    output logic [31:0] lba,
    output logic [15:0] blocks
);

    localparam int IDX_W = $clog2(PKT_WORDS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(PKT_WORDS - 1);

    logic [IDX_W-1:0] idx_q;

    assign done = wr_word && (idx_q == LAST);

    // Purpose: word index within the descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idx_q <= '0;
        end else if (wr_word) begin
            idx_q <= done ? '0 : idx_q + 1'b1;
        end
    end

    // Purpose: store the decoded bytes (opcode, big-endian address and count).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode <= 8'h00;
            lba    <= 32'h0;
            blocks <= 16'h0;
        end else if (wr_word) begin
            case (idx_q)
                IDX_W'(0): opcode       <= wdata[7:0];
                IDX_W'(1): lba[31:16]   <= {wdata[7:0], wdata[15:8]};
                IDX_W'(2): lba[15:0]    <= {wdata[7:0], wdata[15:8]};
                IDX_W'(3): blocks[15:8] <= wdata[15:8];
                IDX_W'(4): blocks[7:0]  <= wdata[7:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/atapi_burst_sizer.sv
// Combinational sizing: normalizes the raw host limit (forced even, zero means
// the largest even value) and picks the next burst as min(remaining, limit).
module atapi_burst_sizer #(
    parameter int REM_W = 27
) (
    input  logic [15:0]      raw_limit,
    input  logic [15:0]      limit,
    input  logic [REM_W-1:0] remaining,
    output logic [15:0]      norm_limit,
    output logic [15:0]      burst
);

    logic [15:0] even_lim;

    // Purpose: round the raw limit down to even and replace zero.
    always_comb begin
        even_lim   = {raw_limit[15:1], 1'b0};
        norm_limit = (even_lim == 16'h0) ? 16'hFFFE : even_lim;
    end

    // Purpose: the burst is the smaller of what remains and the limit.
    always_comb begin
        if (remaining < REM_W'(limit)) begin
            burst = remaining[15:0];
        end else begin
            burst = limit;
        end
    end

endmodule

// File: rtl/atapi_pio_seq.sv
// Top: packet-command PIO sequencer. Accepts the packet command, requests and
// decodes the descriptor, then hands out data in limit-capped bursts, each
// announced by an interrupt. Assumes one host access per cycle, and a stream
// that delivers whole blocks of BLK_BYTES in order once rd_start is seen.
module atapi_pio_seq
    import atapi_seq_pkg::*;
#(
    parameter int BLK_BYTES = 2048,
    parameter int HOLD_CYC  = 4,
    parameter int PKT_WORDS = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hst_wr,
    input  logic        hst_rd,
    input  logic [2:0]  hst_addr,
    input  logic [15:0] hst_wdata,
    output logic [15:0] hst_rdata,
    output logic        irq,
    input  logic [15:0] blk_data,
    input  logic        blk_valid,
    output logic        blk_ready,
    output logic        rd_start,
    output logic [31:0] rd_lba,
    output logic [15:0] rd_blocks
);

    localparam int BLK_SHIFT = $clog2(BLK_BYTES);
    localparam int REM_W     = 16 + BLK_SHIFT;
    localparam int HOLD_W    = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

    seq_state_t         state_q;
    logic [HOLD_W-1:0]  hold_q;
    logic [15:0]        lim_q;
    logic [REM_W-1:0]   rem_q;
    logic [15:0]        wleft_q;
    logic               err_q;
    logic               irq_q;
    logic               start_q;
    logic [31:0]        lba_q;
    logic [15:0]        blocks_q;

    logic cmd_wr, data_wr, stat_rd, data_rd;
    logic cmd_take, pkt_word, pop;
    logic abort_cmd, go_cmd, bad_pkt, empty_pkt, good_pkt;
    logic burst_ev, last_word, done_ev, irq_set;
    logic [7:0] stat_v;

    logic        dma_sel;
    logic [7:0]  tf_nsec, tf_lbal, tf_cntl, tf_cnth, tf_dev;
    logic        pkt_done;
    logic [7:0]  pkt_op;
    logic [31:0] pkt_lba;
    logic [15:0] pkt_blocks;
    logic [15:0] norm_lim, burst;

    // Purpose: decode host strobes and sequencer events.
    always_comb begin
        cmd_wr    = hst_wr && (hst_addr == A_CMD);
        data_wr   = hst_wr && (hst_addr == A_DATA);
        stat_rd   = hst_rd && (hst_addr == A_CMD);
        data_rd   = hst_rd && (hst_addr == A_DATA);
        cmd_take  = cmd_wr && (state_q == SQ_IDLE);
        pkt_word  = data_wr && (state_q == SQ_PKT);
        pop       = data_rd && (state_q == SQ_XFER);
        abort_cmd = cmd_take && !((hst_wdata[7:0] == OP_PACKET) && !dma_sel);
        go_cmd    = cmd_take && !abort_cmd;
        bad_pkt   = pkt_done && (pkt_op != OP_RD10);
        empty_pkt = pkt_done && !bad_pkt && (pkt_blocks == 16'h0);
        good_pkt  = pkt_done && !bad_pkt && (pkt_blocks != 16'h0);
        burst_ev  = (state_q == SQ_PREP) && blk_valid;
        last_word = pop && (wleft_q == 16'd1);
        done_ev   = (last_word && (rem_q == '0)) || empty_pkt;
        irq_set   = abort_cmd || bad_pkt || done_ev || burst_ev;
    end

    atapi_taskfile u_tf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (hst_wr),
        .addr     (hst_addr),
        .wdata    (hst_wdata[7:0]),
        .cnt_load (burst_ev),
        .cnt_val  (burst),
        .dma_sel  (dma_sel),
        .nsec     (tf_nsec),
        .lba_lo   (tf_lbal),
        .cnt_lo   (tf_cntl),
        .cnt_hi   (tf_cnth),
        .dev      (tf_dev)
    );

    atapi_pkt_collect #(.PKT_WORDS(PKT_WORDS)) u_pkt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (go_cmd),
        .wr_word (pkt_word),
        .wdata   (hst_wdata),
        .done    (pkt_done),
        .opcode  (pkt_op),
        .lba     (pkt_lba),
        .blocks  (pkt_blocks)
    );

    atapi_burst_sizer #(.REM_W(REM_W)) u_size (
        .raw_limit  ({tf_cnth, tf_cntl}),
        .limit      (lim_q),
        .remaining  (rem_q),
        .norm_limit (norm_lim),
        .burst      (burst)
    );

    // Purpose: main command sequencer state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SQ_IDLE;
            hold_q   <= '0;
            lim_q    <= 16'hFFFE;
            rem_q    <= '0;
            wleft_q  <= 16'h0;
            err_q    <= 1'b0;
            start_q  <= 1'b0;
            lba_q    <= 32'h0;
            blocks_q <= 16'h0;
        end else begin
            start_q <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (cmd_take) begin
                        err_q <= abort_cmd;
                    end
                    if (go_cmd) begin
                        lim_q   <= norm_lim;
                        hold_q  <= HOLD_W'(HOLD_CYC - 1);
                        state_q <= SQ_HOLD;
                    end
                end
                SQ_HOLD: begin
                    if (hold_q == '0) begin
                        state_q <= SQ_PKT;
                    end else begin
                        hold_q <= hold_q - 1'b1;
                    end
                end
                SQ_PKT: begin
                    if (bad_pkt) begin
                        err_q   <= 1'b1;
                        state_q <= SQ_IDLE;
                    end else if (empty_pkt) begin
                        state_q <= SQ_IDLE;
                    end else if (good_pkt) begin
                        start_q  <= 1'b1;
                        lba_q    <= pkt_lba;
                        blocks_q <= pkt_blocks;
                        rem_q    <= REM_W'(pkt_blocks) << BLK_SHIFT;
                        state_q  <= SQ_PREP;
                    end
                end
                SQ_PREP: begin
                    if (burst_ev) begin
                        rem_q   <= rem_q - REM_W'(burst);
                        wleft_q <= burst >> 1;
                        state_q <= SQ_XFER;
                    end
                end
                SQ_XFER: begin
                    if (pop) begin
                        wleft_q <= wleft_q - 16'd1;
                        if (last_word) begin
                            state_q <= (rem_q == '0) ? SQ_IDLE : SQ_PREP;
                        end
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Purpose: interrupt latch; a new event wins over a clearing access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (irq_set) begin
            irq_q <= 1'b1;
        end else if (stat_rd || cmd_take) begin
            irq_q <= 1'b0;
        end
    end

    // Purpose: status byte derived from the sequencer state.
    always_comb begin
        case (state_q)
            SQ_IDLE:          stat_v = S_READY | (err_q ? S_ERR : 8'h00);
            SQ_HOLD, SQ_PREP: stat_v = S_BUSY | S_READY;
            SQ_PKT, SQ_XFER:  stat_v = S_DREQ | S_READY;
            default:          stat_v = S_READY;
        endcase
    end

    // Purpose: host read data multiplexer.
    always_comb begin
        case (hst_addr)
            A_DATA:  hst_rdata = (state_q == SQ_XFER) ? blk_data : 16'h0;
            A_FEAT:  hst_rdata = {8'h00, err_q ? E_ABORT : 8'h00};
            A_NSEC:  hst_rdata = {8'h00, tf_nsec};
            A_LBAL:  hst_rdata = {8'h00, tf_lbal};
            A_CNTL:  hst_rdata = {8'h00, tf_cntl};
            A_CNTH:  hst_rdata = {8'h00, tf_cnth};
            A_DEV:   hst_rdata = {8'h00, tf_dev};
            default: hst_rdata = {8'h00, stat_v};
        endcase
    end

    assign irq       = irq_q;
    assign blk_ready = pop;
    assign rd_start  = start_q;
    assign rd_lba    = lba_q;
    assign rd_blocks = blocks_q;

endmodule

// File: rtl/atapi_pio_seq_chk.sv
// Checker: temporal properties of the sequencer, attached by bind.
module atapi_pio_seq_chk
    import atapi_seq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        hst_wr,
    input logic        hst_rd,
    input logic [2:0]  hst_addr,
    input logic        irq,
    input logic        blk_valid,
    input logic        blk_ready,
    input logic        rd_start,
    input seq_state_t  state_q,
    input logic [7:0]  stat_v,
    input logic [15:0] lim_q,
    input logic [7:0]  tf_cntl,
    input logic [7:0]  tf_cnth
);

    // R2: busy and data request never coexist
    p_busy_dreq_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !((stat_v & S_BUSY) != 8'h0 && (stat_v & S_DREQ) != 8'h0));

    // R3: start is a single-cycle pulse
    p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !rd_start);

    // R4: the active limit is even and nonzero
    p_limit_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SQ_IDLE) |-> (lim_q[0] == 1'b0 && lim_q != 16'h0));

    // R5: a reported burst never exceeds the limit
    p_burst_fits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_PREP && blk_valid) |=>
            ({tf_cnth, tf_cntl} <= lim_q && {tf_cnth, tf_cntl} != 16'h0));

    // R5: stream words are only consumed while data is requested
    p_pop_in_dreq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        blk_ready |-> ((stat_v & S_DREQ) != 8'h0));

    // R6: a status read clears the interrupt unless a burst is announced
    p_stat_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_rd && hst_addr == A_CMD && !(state_q == SQ_PREP && blk_valid))
            |=> !irq);

    // R10: command writes during a data-request phase do not move the state
    p_cmd_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_wr && !hst_rd && hst_addr == A_CMD &&
         (state_q == SQ_PKT || state_q == SQ_XFER)) |=> $stable(state_q));

    // R11: no announcement while the stream stalls
    p_stall_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_PREP && !blk_valid && !irq) |=> !irq);

endmodule

bind atapi_pio_seq atapi_pio_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hst_wr    (hst_wr),
    .hst_rd    (hst_rd),
    .hst_addr  (hst_addr),
    .irq       (irq),
    .blk_valid (blk_valid),
    .blk_ready (blk_ready),
    .rd_start  (rd_start),
    .state_q   (state_q),
    .stat_v    (stat_v),
    .lim_q     (lim_q),
    .tf_cntl   (tf_cntl),
    .tf_cnth   (tf_cnth)
);

// File: tb/sim_atapi_pio_seq.sv
`timescale 1ns/1ps
module sim_atapi_pio_seq;

    localparam int BLK = 256;
    localparam int HOLD = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_wr = 1'b0;
    logic        hst_rd = 1'b0;
    logic [2:0]  hst_addr = 3'd0;
    logic [15:0] hst_wdata = 16'h0;
    logic [15:0] hst_rdata;
    logic        irq;
    logic [15:0] blk_data;
    logic        blk_valid = 1'b1;
    logic        blk_ready;
    logic        rd_start;
    logic [31:0] rd_lba;
    logic [15:0] rd_blocks;

    int n_chk = 0;
    int n_bad = 0;
    int src_idx = 0;
    int exp_idx = 0;

    always #5 clk = ~clk;

    atapi_pio_seq #(.BLK_BYTES(BLK), .HOLD_CYC(HOLD), .PKT_WORDS(6)) u0 (
        .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .irq(irq), .blk_data(blk_data), .blk_valid(blk_valid),
        .blk_ready(blk_ready), .rd_start(rd_start), .rd_lba(rd_lba),
        .rd_blocks(rd_blocks)
    );

    function automatic logic [15:0] wfn(input int n);
        return 16'(n * 953 + 16'h1234);
    endfunction

    // media stream model
    assign blk_data = wfn(src_idx);
    always @(posedge clk) if (blk_ready) src_idx <= src_idx + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
        @(negedge clk);
        hst_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        hst_rd = 1'b1; hst_addr = a;
        #1 d = hst_rdata;
        @(negedge clk);
        hst_rd = 1'b0;
    endtask

    task automatic wait_irq(input string tag);
        for (int i = 0; i < 100 && !irq; i++) @(negedge clk);
        check(tag, irq, 1);
    endtask

    task automatic send_pkt(input logic [7:0] op, input logic [31:0] lba, input logic [15:0] nb);
        wr(0, {8'h00, op});
        wr(0, {lba[23:16], lba[31:24]});
        wr(0, {lba[7:0], lba[15:8]});
        wr(0, {nb[15:8], 8'h00});
        wr(0, {8'h00, nb[7:0]});
        wr(0, 16'h0000);
    endtask

    task automatic issue(input logic [15:0] limit);
        logic [15:0] v;
        wr(4, {8'h00, limit[7:0]});
        wr(5, {8'h00, limit[15:8]});
        wr(1, 16'h0000);
        wr(7, 16'h00A0);
        rd(7, v);
        check("R2 busy after packet command", v, 16'h00C0);
        for (int i = 0; i < 20 && v[7]; i++) rd(7, v);
        check("R2 packet request status", v, 16'h0048);
        check("R2 no irq on packet request", irq, 0);
    endtask

    task automatic run_read(input logic [15:0] limit, input int nb, input logic [31:0] lba,
                            input bit stall, input bit probe);
        logic [15:0] v, lo, hi, d;
        int eff, rem, burst, errs;
        bit first;
        issue(limit);
        if (stall) blk_valid = 1'b0;
        send_pkt(8'h28, lba, 16'(nb));
        check("R3 start pulse", rd_start, 1);
        check("R3 decoded address", rd_lba, lba);
        check("R3 decoded count", rd_blocks, nb);
        @(negedge clk);
        check("R3 start pulse width", rd_start, 0);
        eff = int'(limit) & 32'hFFFE;
        if (eff == 0) eff = 32'hFFFE;
        rem = nb * BLK;
        if (stall) begin
            repeat (8) @(negedge clk);
            rd(7, v);
            check("R11 busy while stalled", v, 16'h00C0);
            check("R11 no irq while stalled", irq, 0);
            blk_valid = 1'b1;
        end
        first = 1'b1;
        while (rem > 0) begin
            burst = (rem < eff) ? rem : eff;
            wait_irq("R5 burst interrupt");
            rd(7, v);
            check("R5 burst status", v, 16'h0048);
            check("R6 status read clears irq", irq, 0);
            rd(4, lo);
            rd(5, hi);
            check("R4 R5 burst byte count", {hi[7:0], lo[7:0]}, burst);
            errs = 0;
            for (int w = 0; w < burst / 2; w++) begin
                if (probe && first && w == 0) begin
                    wr(7, 16'h00EC);
                    rd(7, v);
                    check("R10 command ignored mid-transfer", v, 16'h0048);
                end
                if (probe && first && w == burst / 2 - 1 && rem > burst) begin
                    repeat (6) @(negedge clk);
                    check("R6 no early announce", irq, 0);
                    rd(7, v);
                    check("R6 still draining", v, 16'h0048);
                end
                rd(0, d);
                if (d !== wfn(exp_idx)) errs++;
                exp_idx++;
            end
            check("R5 burst data order", errs, 0);
            rem -= burst;
            first = 1'b0;
        end
        wait_irq("R7 completion interrupt");
        rd(7, v);
        check("R7 final status", v, 16'h0040);
        check("R7 irq cleared", irq, 0);
        check("R5 words consumed", src_idx, exp_idx);
    endtask

    localparam logic [15:0] LIMS [8] = '{16'h0101, 16'h0100, 16'h00C0, 16'h0050,
                                         16'h0003, 16'h0000, 16'h0001, 16'h0300};

    initial begin
        logic [15:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(7, v);
        check("R1 reset status", v, 16'h0040);
        check("R1 reset irq", irq, 0);
        check("R1 reset no pop", blk_ready, 0);
        check("R1 reset no start", rd_start, 0);

        for (int li = 0; li < 8; li++)
            for (int nb = 1; nb <= 3; nb++)
                run_read(LIMS[li], nb, 32'h0102_0304 + 32'(li * 17 + nb),
                         (li == 2 && nb == 2), (nb == 2));

        // R8: zero block count
        issue(16'h0100);
        send_pkt(8'h28, 32'h0000_0010, 16'h0000);
        check("R8 immediate completion irq", irq, 1);
        check("R8 no start pulse", rd_start, 0);
        rd(7, v);
        check("R8 status after empty read", v, 16'h0040);
        check("R8 no words consumed", src_idx, exp_idx);

        // R9: bad descriptor opcode
        issue(16'h0100);
        send_pkt(8'h12, 32'h0, 16'h0001);
        check("R9 abort irq on bad opcode", irq, 1);
        rd(7, v);
        check("R9 abort status bad opcode", v, 16'h0041);
        rd(1, v);
        check("R9 abort code bad opcode", v, 16'h0004);

        // R9: unsupported command
        wr(1, 16'h0000);
        wr(7, 16'h00EC);
        check("R9 abort irq on other command", irq, 1);
        rd(7, v);
        check("R9 abort status other command", v, 16'h0041);

        // R9: DMA data path requested
        wr(1, 16'h0001);
        wr(7, 16'h00A0);
        check("R9 abort irq on DMA request", irq, 1);
        rd(7, v);
        check("R9 abort status DMA request", v, 16'h0041);
        rd(1, v);
        check("R9 abort code DMA request", v, 16'h0004);

        // R9: next good command clears the error
        run_read(16'h0080, 1, 32'h0000_0042, 1'b0, 1'b0);
        rd(1, v);
        check("R9 error cleared by next command", v, 16'h0000);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule